// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block turns an accepted 8-bit interrupt vector into a dispatch decision. On a start pulse it captures the vector, the current privilege level, the current flags word, and the descriptor table's base and limit. It checks that the whole 8-byte entry lies inside the table. It then fetches the entry as two 32-bit words through a read port with a valid/ready handshake, decodes the gate kind and checks privilege. The result is one of three outcomes. A handler call gives a target selector and offset. A task-switch request carries the gate's selector. A general-protection fault (vector 13) replaces the dispatch when a check fails.

For a handler call the block also gives the flags word to push, which is the flags captured at start, and the flags word to install afterwards. Both gate kinds clear the trap flag. Only the interrupt gate also clears the interrupt-enable flag. The descriptor format is fixed:
- The low word holds the selector in bits 31:16 and offset bits 15:0 in bits 15:0.
- The high word holds offset bits 31:16 in bits 31:16 and the gate type in bits 11:8.
- The target privilege is taken from the selector's two low bits.

The sequencer has five states: S_IDLE, S_READ_LO, S_READ_HI, S_CHECK and S_DONE. Its transitions are:
- S_IDLE moves to S_READ_LO on start when the entry is in range, or straight to S_DONE with a fault when it is not.
- S_READ_LO moves to S_READ_HI, and S_READ_HI to S_CHECK, each on an accepted read.
- S_CHECK always moves to S_DONE.
- S_DONE always returns to S_IDLE.

Top module: `gate_dispatch_seq`

## Requirements
- R1: After reset, busy, done and rd_valid are 0 and kind is 0 (none). Kind codes are 0 none, 1 handler call, 2 task switch, 3 general-protection fault.
- R2: The entry is read as two words, first at base + vector*8, then at base + vector*8 + 4.
- R3: If vector*8 + 7 exceeds the table limit, the result is a fault with out_vec = 13 and no read is issued. Done rises one cycle after the start edge.
- R4: While rd_valid is high and rd_ready is low, rd_valid and rd_addr stay unchanged. A stall of s cycles on each read gives done 4 + 2s cycles after the start edge.
- R5: Gate type 0xE (interrupt gate) gives kind 1, with selector = low[31:16] and offset = {high[31:16], low[15:0]}. new_flags clears bit 8 (trap) and bit 9 (interrupt enable).
- R6: Gate type 0xF (trap gate) gives kind 1 with the same fields, but new_flags clears only bit 8.
- R7: push_flags equals the flags input captured at start, for every outcome.
- R8: Gate type 0x5 (task gate) gives kind 2 with the gate selector and out_vec equal to the vector. new_flags equals the captured flags.
- R9: For a type 0xE or 0xF gate, if the selector's bits 1:0 are numerically greater than the current privilege level, the result is a fault with out_vec 13.
- R10: Any gate type other than 0x5, 0xE or 0xF gives a fault with out_vec 13, and new_flags equals the captured flags.
- R11: A start pulse while busy is ignored; the running dispatch completes with its own result.
- R12: done is a one-cycle pulse. All result outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a dispatch (honoured only when idle) |
| vec | input | 8 | Vector to dispatch |
| cpl | input | 2 | Current privilege level |
| flags | input | 32 | Current flags word |
| tbl_base | input | 32 | Descriptor table linear base |
| tbl_limit | input | 16 | Descriptor table limit (last valid byte offset) |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Dispatch in progress |
| done | output | 1 | One-cycle result pulse |
| kind | output | 2 | Outcome code |
| out_vec | output | 8 | Vector actually delivered (13 on fault) |
| out_sel | output | 16 | Target or task selector |
| out_off | output | 32 | Handler offset |
| push_flags | output | 32 | Flags word to push |
| new_flags | output | 32 | Flags word after dispatch |

## Verification
A range fault gives done one cycle after the start edge. A fetched gate gives done four cycles after the start edge, plus twice the per-read stall that the bench's memory responder inserts. The bench counts falling edges from the start edge and checks that done appears exactly at that count. It reads every result field in that cycle. One cycle later it confirms that done has dropped and the fields are unchanged. The responder logs each accepted read address, so the bench can check both the order of the reads and that none occurs after a range fault.

// File: rtl/gds_pkg.sv
package gds_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_READ_LO, S_READ_HI, S_CHECK, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NONE = 2'd0, K_CALL = 2'd1, K_TASK = 2'd2, K_GP = 2'd3
    } disp_kind_t;

    localparam logic [3:0] GATE_TASK = 4'h5;
    localparam logic [3:0] GATE_INTR = 4'hE;
    localparam logic [3:0] GATE_TRAP = 4'hF;

    typedef struct packed {
        disp_kind_t  kind;
        logic [7:0]  vec;
        logic [15:0] sel;
        logic [31:0] off;
        logic [31:0] push_flags;
        logic [31:0] new_flags;
    } disp_res_t;
endpackage

// File: rtl/gds_addr.sv
module gds_addr #(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [VEC_W-1:0]  vec,
    input  logic              upper,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam int SPAN_W = VEC_W + 3;
    localparam int CMP_W  = (SPAN_W > LIM_W) ? SPAN_W : LIM_W;

    logic [SPAN_W-1:0] last_byte;
    logic [SPAN_W-1:0] word_off;

    always_comb begin
        last_byte = {vec, 3'b111};
        word_off  = {vec, upper, 2'b00};
        in_range  = CMP_W'(last_byte) <= CMP_W'(limit);
        addr      = base + ADDR_W'(word_off);
    end
endmodule

// File: rtl/gds_decode.sv
module gds_decode
    import gds_pkg::*;
#(
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9,
    parameter int GP_VEC = 13
) (
    input  logic [31:0] lo_word,
    input  logic [31:0] hi_word,
    input  logic [31:0] flags,
    input  logic [1:0]  cpl,
    input  logic [7:0]  vec,
    output disp_res_t   res
);
    logic [3:0]  gate_type;
    logic [15:0] sel;
    logic [31:0] off;
    logic        priv_bad;

    always_comb begin
        gate_type = hi_word[11:8];
        sel       = lo_word[31:16];
        off       = {hi_word[31:16], lo_word[15:0]};
        priv_bad  = sel[1:0] > cpl;

        res            = '0;
        res.kind       = K_GP;
        res.vec        = 8'(GP_VEC);
        res.push_flags = flags;
        res.new_flags  = flags;

        case (gate_type)
            GATE_TASK: begin
                res.kind = K_TASK;
                res.vec  = vec;
                res.sel  = sel;
            end
            GATE_INTR, GATE_TRAP: begin
                if (!priv_bad) begin
                    res.kind              = K_CALL;
                    res.vec               = vec;
                    res.sel               = sel;
                    res.off               = off;
                    res.new_flags[TF_BIT] = 1'b0;
                    if (gate_type == GATE_INTR) begin
                        res.new_flags[IF_BIT] = 1'b0;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gds_fsm.sv
module gds_fsm
    import gds_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16,
    parameter int GP_VEC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic [1:0]        cpl_in,
    input  logic [31:0]       flags_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LIM_W-1:0]  limit_in,
    input  logic              in_range,
    input  disp_res_t         dec_res,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              upper,
    output logic [VEC_W-1:0]  cur_vec,
    output logic [ADDR_W-1:0] cur_base,
    output logic [LIM_W-1:0]  cur_limit,
    output logic [31:0]       lo_q,
    output logic [31:0]       hi_q,
    output logic [1:0]        cpl_q,
    output logic [31:0]       flags_q,
    output disp_res_t         res_q,
    output logic              busy,
    output logic              done
);
    seq_state_t state, state_nx;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] base_q;
    logic [LIM_W-1:0]  limit_q;
    logic              idle;

    assign idle = (state == S_IDLE);

    always_comb begin
        cur_vec   = idle ? vec_in   : vec_q;
        cur_base  = idle ? base_in  : base_q;
        cur_limit = idle ? limit_in : limit_q;
        rd_valid  = (state == S_READ_LO) || (state == S_READ_HI);
        upper     = (state == S_READ_HI);
        busy      = !idle;
        done      = (state == S_DONE);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = in_range ? S_READ_LO : S_DONE;
            S_READ_LO: if (rd_ready) state_nx = S_READ_HI;
            S_READ_HI: if (rd_ready) state_nx = S_CHECK;
            S_CHECK:   state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q   <= '0;
            base_q  <= '0;
            limit_q <= '0;
            cpl_q   <= '0;
            flags_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            res_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    vec_q   <= vec_in;
                    base_q  <= base_in;
                    limit_q <= limit_in;
                    cpl_q   <= cpl_in;
                    flags_q <= flags_in;
                    if (!in_range) begin
                        res_q            <= '0;
                        res_q.kind       <= K_GP;
                        res_q.vec        <= 8'(GP_VEC);
                        res_q.push_flags <= flags_in;
                        res_q.new_flags  <= flags_in;
                    end
                end
                S_READ_LO: if (rd_ready) lo_q <= rd_data;
                S_READ_HI: if (rd_ready) hi_q <= rd_data;
                S_CHECK:   res_q <= dec_res;
                S_DONE:    ;
                default:   ;
            endcase
        end
    end

    a_r3_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !in_range) |=> (done && res_q.kind == K_GP && !rd_valid));

    a_r9_call_privilege: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_q.kind == K_CALL) |-> (res_q.sel[1:0] <= cpl_q));
endmodule

// File: rtl/gate_dispatch_seq.sv
module gate_dispatch_seq
    import gds_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16,
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9,
    parameter int GP_VEC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  vec,
    input  logic [1:0]        cpl,
    input  logic [31:0]       flags,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        kind,
    output logic [7:0]        out_vec,
    output logic [15:0]       out_sel,
    output logic [31:0]       out_off,
    output logic [31:0]       push_flags,
    output logic [31:0]       new_flags
);
    logic              upper, in_range;
    logic [VEC_W-1:0]  cur_vec;
    logic [ADDR_W-1:0] cur_base;
    logic [LIM_W-1:0]  cur_limit;
    logic [31:0]       lo_q, hi_q, flags_q;
    logic [1:0]        cpl_q;
    disp_res_t         dec_res, res_q;

    gds_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_addr (
        .base(cur_base), .limit(cur_limit), .vec(cur_vec), .upper(upper),
        .addr(rd_addr), .in_range(in_range)
    );

    gds_decode #(.TF_BIT(TF_BIT), .IF_BIT(IF_BIT), .GP_VEC(GP_VEC)) u_dec (
        .lo_word(lo_q), .hi_word(hi_q), .flags(flags_q), .cpl(cpl_q),
        .vec(8'(cur_vec)), .res(dec_res)
    );

    gds_fsm #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W), .GP_VEC(GP_VEC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec), .cpl_in(cpl),
        .flags_in(flags), .base_in(tbl_base), .limit_in(tbl_limit),
        .in_range(in_range), .dec_res(dec_res), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .upper(upper),
        .cur_vec(cur_vec), .cur_base(cur_base), .cur_limit(cur_limit),
        .lo_q(lo_q), .hi_q(hi_q), .cpl_q(cpl_q), .flags_q(flags_q),
        .res_q(res_q), .busy(busy), .done(done)
    );

    always_comb begin
        kind       = res_q.kind;
        out_vec    = res_q.vec;
        out_sel    = res_q.sel;
        out_off    = res_q.off;
        push_flags = res_q.push_flags;
        new_flags  = res_q.new_flags;
    end

    a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_call_clears_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == K_CALL) |-> !new_flags[TF_BIT]);

    a_r7_push_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(push_flags));
endmodule

// File: tb/gate_dispatch_seq_test.sv
module gate_dispatch_seq_test;
    typedef struct packed {
        logic [7:0]  v;
        logic [1:0]  cpl;
        logic [15:0] lim;
        logic [31:0] flg;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [3:0]  stall;
        logic [1:0]  kind;
        logic [15:0] sel;
        logic [31:0] off;
        logic [31:0] nflg;
    } vec_t;

    localparam int NV = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam vec_t TBL [NV] = '{
        '{8'h20, 2'd0, 16'h03FF, 32'h302, 32'h0008_1234, 32'hABCD_8E00, 4'd0, 2'd1, 16'h0008, 32'hABCD_1234, 32'h002},
        '{8'h21, 2'd0, 16'h03FF, 32'h302, 32'h0010_5678, 32'h0040_8F00, 4'd3, 2'd1, 16'h0010, 32'h0040_5678, 32'h202},
        '{8'h05, 2'd0, 16'h03FF, 32'h302, 32'h0028_0000, 32'h0000_8500, 4'd1, 2'd2, 16'h0028, 32'h0, 32'h302},
        '{8'h22, 2'd0, 16'h03FF, 32'h302, 32'h000B_1111, 32'h2222_8E00, 4'd0, 2'd3, 16'h0, 32'h0, 32'h302},
        '{8'h23, 2'd3, 16'h03FF, 32'h246, 32'h001B_4444, 32'h5555_8E00, 4'd2, 2'd1, 16'h001B, 32'h5555_4444, 32'h046},
        '{8'h24, 2'd0, 16'h03FF, 32'h302, 32'h0008_0000, 32'h0000_8C00, 4'd0, 2'd3, 16'h0, 32'h0, 32'h302},
        '{8'h25, 2'd2, 16'h03FF, 32'h100, 32'h0009_9999, 32'h8888_8F00, 4'd5, 2'd1, 16'h0009, 32'h8888_9999, 32'h000},
        '{8'h80, 2'd0, 16'h03FF, 32'h302, 32'h0, 32'h0, 4'd0, 2'd3, 16'h0, 32'h0, 32'h302},
        '{8'h7F, 2'd0, 16'h03FF, 32'h200, 32'h0030_0001, 32'h0002_8F00, 4'd0, 2'd1, 16'h0030, 32'h0002_0001, 32'h200},
        '{8'h7E, 2'd0, 16'h03F6, 32'h202, 32'h0008_0000, 32'h0000_8E00, 4'd0, 2'd3, 16'h0, 32'h0, 32'h202}
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic [7:0] vec = 0;
    logic [1:0] cpl = 0;
    logic [31:0] flags = 0, tbl_base = BASE, rd_data = 0;
    logic [15:0] tbl_limit = 0;
    logic rd_valid, rd_ready = 0, busy, done;
    logic [31:0] rd_addr, out_off, push_flags, new_flags;
    logic [1:0] kind;
    logic [7:0] out_vec;
    logic [15:0] out_sel;

    int nchk = 0, nerr = 0;
    int stall_cfg = 0, wait_cnt = 0, nreads = 0;
    bit gave_ready = 0;
    logic [31:0] rlog [0:3];
    logic [31:0] bmem [0:255];

    always #2 clk = ~clk;

    gate_dispatch_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec(vec), .cpl(cpl),
        .flags(flags), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .busy(busy), .done(done), .kind(kind),
        .out_vec(out_vec), .out_sel(out_sel), .out_off(out_off),
        .push_flags(push_flags), .new_flags(new_flags)
    );

    always @(negedge clk) begin
        if (gave_ready) wait_cnt = 0;
        rd_ready = 0;
        if (rd_valid) begin
            if (wait_cnt < stall_cfg) begin
                wait_cnt = wait_cnt + 1;
            end else begin
                rd_ready = 1;
                rd_data  = bmem[8'((rd_addr - BASE) >> 2)];
                if (nreads < 4) rlog[nreads] = rd_addr;
                nreads = nreads + 1;
            end
        end
        gave_ready = rd_ready;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input vec_t t);
        vec = t.v; cpl = t.cpl; flags = t.flg; tbl_limit = t.lim;
        stall_cfg = int'(t.stall); nreads = 0; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input vec_t t, input int lat);
        bit fault = (t.kind == 2'd3);
        int exp_lat = fault && (t.lim < {5'd0, t.v, 3'b111}) ? 1 : 4 + 2 * int'(t.stall);
        chk("R4 latency", 32'(lat), 32'(exp_lat));
        chk("R12 done", 32'(done), 32'd1);
        chk("R5/R6/R8/R9/R10 kind", 32'(kind), 32'(t.kind));
        chk("R9/R10 out_vec", 32'(out_vec), fault ? 32'd13 : 32'(t.v));
        if (!fault) chk("R5 R8 selector", 32'(out_sel), 32'(t.sel));
        if (t.kind == 2'd1) chk("R5 R6 offset", out_off, t.off);
        chk("R7 push_flags", push_flags, t.flg);
        chk("R5 R6 new_flags", new_flags, t.nflg);
        if (exp_lat == 1) begin
            chk("R3 no reads", 32'(nreads), 32'd0);
        end else begin
            chk("R2 read count", 32'(nreads), 32'd2);
            chk("R2 first addr", rlog[0], BASE + 32'(t.v) * 8);
            chk("R2 second addr", rlog[1], BASE + 32'(t.v) * 8 + 4);
        end
        @(negedge clk);
        chk("R12 done drops", 32'(done), 32'd0);
        chk("R12 kind held", 32'(kind), 32'(t.kind));
        chk("R12 flags held", new_flags, t.nflg);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        int lat;
        for (int i = 0; i < 256; i++) bmem[i] = 32'hDEAD_0000 | 32'(i);
        for (int i = 0; i < NV; i++) begin
            bmem[{TBL[i].v[6:0], 1'b0}] = TBL[i].lo;
            bmem[{TBL[i].v[6:0], 1'b1}] = TBL[i].hi;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 kind", 32'(kind), 32'd0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            launch(TBL[i]);
            wait_done(lat);
            check_result(TBL[i], lat);
            @(negedge clk);
        end

        // R11: start while busy is ignored
        launch(TBL[1]);
        vec = 8'h20; cpl = 2'd0; flags = 32'h0; start = 1;
        @(negedge clk);
        start = 0;
        wait_done(lat);
        lat = lat + 1;
        chk("R11 kind", 32'(kind), 32'(TBL[1].kind));
        chk("R11 offset", out_off, TBL[1].off);
        chk("R11 push_flags", push_flags, TBL[1].flg);
        chk("R11 latency", 32'(lat), 32'(4 + 2 * int'(TBL[1].stall)));
        @(negedge clk);
        chk("R11 idle after", 32'(busy), 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule